// File: doc/BRIEF.md
# AXI4-Lite FIFO Push Bridge

This block lets a processor with a 32-bit AXI4-Lite bus feed 40-bit work items into a 16-entry synchronous FIFO. A downstream consumer drains the FIFO through a head-data bus, an empty flag and a pop strobe. Because an item is wider than one bus word, software sends it in two writes. The first write goes to the upper-word address and stores only bits 39:32. The second write goes to the lower-word address. It joins the stored byte with the new 32 bits and pushes the result into the FIFO. The two data addresses hold nothing that can be read back. A write to them only causes a side effect.

A control/status word carries a run-enable bit that starts and stops the consumer. It also reports the FIFO's empty and full flags and a sticky overflow flag. The overflow flag is set whenever a push is dropped because the FIFO is full. The slave handles single-beat transfers only and takes no notice of write strobes.

The write channel is a four-state machine. The states are WR_IDLE, WR_GOT_ADDR, WR_GOT_DATA and WR_RESP, and the transitions are:
- WR_IDLE goes to WR_RESP when address and data arrive together.
- WR_IDLE goes to WR_GOT_ADDR when only the address arrives.
- WR_IDLE goes to WR_GOT_DATA when only the data arrives.
- WR_GOT_ADDR goes to WR_RESP when the data arrives.
- WR_GOT_DATA goes to WR_RESP when the address arrives.
- WR_RESP goes to WR_IDLE when the response is accepted.

The register update (the commit) happens on the edge that enters WR_RESP. The read channel has two states:
- RD_IDLE goes to RD_RESP when an address is accepted, and the read value is captured at that moment.
- RD_RESP goes to RD_IDLE when the response is accepted.

Top module: `fifo_push_bridge`

## Requirements
- R1: After reset:
  - s_bvalid and s_rvalid are low.
  - cons_empty is high and cons_run is low.
  - A read of the control/status word returns 0x2.
- R2: The write address and write data channels may complete in either order or in the same cycle. s_bvalid rises only in the cycle after both have been accepted, stays high until s_bready, and s_bresp is 0 (OKAY).
- R3: A write to offset 0x0 stores wdata[7:0] as the item's upper byte. A write to offset 0x4 pushes the item {upper byte, wdata[31:0]}. The stored upper byte stays in place across any number of pushes.
- R4: The FIFO is first-in first-out. cons_data shows the oldest item whenever cons_empty is low. A cons_pop while the FIFO is not empty removes that item at the clock edge.
- R5: A cons_pop while cons_empty is high has no effect.
- R6: The FIFO holds 16 items, and the full flag is set when it holds 16. A push to a full FIFO drops the item, sets the sticky overflow flag and still answers OKAY.
- R7: Writing offset 0x8 behaves as follows:
  - wdata[0] is loaded into run-enable, which drives cons_run.
  - A 1 in wdata[3] clears the overflow flag, and a 0 there leaves it as it is.
- R8: Reads return the following:
  - Offsets 0x0 and 0x4 return 0.
  - Offset 0x8 returns run-enable in bit 0, empty in bit 1, full in bit 2 and overflow in bit 3.
  - s_rresp is 0.
  - s_rvalid and s_rdata are held until s_rready.
- R9: A write to the unmapped offset 0xC is acknowledged and changes nothing. s_wstrb has no effect on any write.
- R10: A push and a cons_pop in the same cycle both take effect when the FIFO is neither full nor empty, so the item count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 4 | Write address (byte offset) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address (byte offset) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| cons_run | output | 1 | Run-enable to the consumer |
| cons_empty | output | 1 | FIFO empty |
| cons_data | output | 40 | FIFO head item |
| cons_pop | input | 1 | Consumer pop strobe |

## Verification
The hardest case to reach is a push and a pop on the same edge. The commit happens only on the single clock edge where the second of the two write channels is accepted, so the consumer's pop has to be lined up with that edge. The bench reaches it by raising cons_pop during a write that presents address and data together, so that the commit edge is known in advance. It repeats this at both fill boundaries: with the FIFO full, where the push must be dropped while the pop proceeds, and with it partly filled. A model queue predicts the head, the flags and the overflow bit throughout a long random mix of writes, reads and pops, with channel orders and response stalls also chosen at random.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    typedef enum logic [1:0] {
        WR_IDLE     = 2'd0,
        WR_GOT_ADDR = 2'd1,
        WR_GOT_DATA = 2'd2,
        WR_RESP     = 2'd3
    } wr_state_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_t;

    typedef enum logic [1:0] {
        SEL_UPPER = 2'd0,
        SEL_LOWER = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    localparam int BIT_RUN   = 0;
    localparam int BIT_EMPTY = 1;
    localparam int BIT_FULL  = 2;
    localparam int BIT_OVF   = 3;
endpackage

// File: rtl/axil_write_fsm.sv
module axil_write_fsm
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    wr_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (awvalid && wvalid) state_d = WR_RESP;
                else if (awvalid)      state_d = WR_GOT_ADDR;
                else if (wvalid)       state_d = WR_GOT_DATA;
            end
            WR_GOT_ADDR: if (wvalid)  state_d = WR_RESP;
            WR_GOT_DATA: if (awvalid) state_d = WR_RESP;
            WR_RESP:     if (bready)  state_d = WR_IDLE;
            default:                  state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        awready     = (state_q == WR_IDLE) || (state_q == WR_GOT_DATA);
        wready      = (state_q == WR_IDLE) || (state_q == WR_GOT_ADDR);
        bvalid      = (state_q == WR_RESP);
        commit      = (state_q != WR_RESP) && (state_d == WR_RESP);
        commit_addr = (state_q == WR_GOT_ADDR) ? addr_q : awaddr;
        commit_data = (state_q == WR_GOT_DATA) ? data_q : wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (awvalid && awready) addr_q <= awaddr;
            if (wvalid && wready)   data_q <= wdata;
        end
    end
endmodule

// File: rtl/axil_read_fsm.sv
module axil_read_fsm
    import bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] rd_value
);
    rd_state_t         state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (arvalid) state_d = RD_RESP;
            RD_RESP: if (rready)  state_d = RD_IDLE;
            default:              state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        arready = (state_q == RD_IDLE);
        rvalid  = (state_q == RD_RESP);
        rdata   = rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (arvalid && arready) rdata_q <= rd_value;
    end
endmodule

// File: rtl/item_fifo.sv
module item_fifo #(
    parameter int WIDTH = 40,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/fifo_push_bridge.sv
module fifo_push_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int ITEM_W = 40,
    parameter int DEPTH  = 16,
    localparam int HI_W   = ITEM_W - DATA_W,
    localparam int WORD_W = ADDR_W - 2,
    localparam int STRB_W = DATA_W / 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              cons_run,
    output logic              cons_empty,
    output logic [ITEM_W-1:0] cons_data,
    input  logic              cons_pop
);
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] rd_value;
    reg_sel_t          wr_sel;
    logic [HI_W-1:0]   hi_q;
    logic              run_q, ovf_q;
    logic              push_req, fifo_full;
    logic [CNT_W-1:0]  fifo_count;
    logic              unused_bits;

    assign unused_bits = ^{s_wstrb, commit_addr[1:0], s_araddr[1:0]};

    axil_write_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
    );

    axil_read_fsm #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
        .rd_value(rd_value)
    );

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    always_comb begin
        unique case (commit_addr[ADDR_W-1:2])
            WORD_W'(0): wr_sel = SEL_UPPER;
            WORD_W'(1): wr_sel = SEL_LOWER;
            WORD_W'(2): wr_sel = SEL_CTRL;
            default:    wr_sel = SEL_NONE;
        endcase
    end

    assign push_req = commit && (wr_sel == SEL_LOWER);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            run_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (commit) begin
            unique case (wr_sel)
                SEL_UPPER: hi_q <= commit_data[HI_W-1:0];
                SEL_LOWER: if (fifo_full) ovf_q <= 1'b1;
                SEL_CTRL: begin
                    run_q <= commit_data[BIT_RUN];
                    if (commit_data[BIT_OVF]) ovf_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    item_fifo #(.WIDTH(ITEM_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push_req), .push_data({hi_q, commit_data}),
        .pop(cons_pop), .head(cons_data),
        .empty(cons_empty), .full(fifo_full), .count(fifo_count)
    );

    assign cons_run = run_q;

    always_comb begin
        rd_value = '0;
        if (s_araddr[ADDR_W-1:2] == WORD_W'(2)) begin
            rd_value[BIT_RUN]   = run_q;
            rd_value[BIT_EMPTY] = cons_empty;
            rd_value[BIT_FULL]  = fifo_full;
            rd_value[BIT_OVF]   = ovf_q;
        end
    end
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int DEPTH = 16,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_awready,
    input logic              s_wready,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [DATA_W-1:0] s_rdata,
    input logic              cons_empty,
    input logic              cons_pop,
    input logic              push_req,
    input logic              fifo_full,
    input logic              ovf_q,
    input logic [CNT_W-1:0]  fifo_count
);
    p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid);

    p_no_accept_in_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready && !s_wready);

    p_rvalid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    p_drop_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && fifo_full |=> ovf_q);

    p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cons_pop && cons_empty && !push_req |=> cons_empty);

    p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && cons_pop && !fifo_full && !cons_empty |=> $stable(fifo_count));
endmodule

bind fifo_push_bridge bridge_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .s_awready(s_awready), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .cons_empty(cons_empty), .cons_pop(cons_pop),
    .push_req(push_req), .fifo_full(fifo_full),
    .ovf_q(ovf_q), .fifo_count(fifo_count)
);

// File: tb/fifo_push_bridge_test.sv
module fifo_push_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [3:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic        cons_run;
    logic        cons_empty;
    logic [39:0] cons_data;
    logic        cons_pop = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [39:0] model_q[$];
    logic [7:0]  hi_m = '0;
    logic        run_m = 1'b0;
    logic        ovf_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_push_bridge uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {28'd0, ovf_m, model_q.size() == DEPTH, model_q.size() == 0, run_m};
    endfunction

    task automatic check_state();
        chk(cons_empty == (model_q.size() == 0), "R4 empty flag", 64'(cons_empty), 64'(model_q.size() == 0));
        if (model_q.size() != 0)
            chk(cons_data == model_q[0], "R4 head data", 64'(cons_data), 64'(model_q[0]));
        chk(cons_run == run_m, "R7 run enable", 64'(cons_run), 64'(run_m));
    endtask

    // mode 0: together, 1: address first, 2: data first
    task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input int mode,
                             input int stall, input bit pop_at_commit);
        bit aw_done = 0, w_done = 0, fa, fw;
        s_awaddr = a;
        s_wdata  = d;
        s_wstrb  = 4'($urandom_range(0, 15));
        while (!(aw_done && w_done)) begin
            s_awvalid = !aw_done && (mode != 2 || w_done);
            s_wvalid  = !w_done && (mode != 1 || aw_done);
            cons_pop  = pop_at_commit && (mode == 0);
            #1;
            fa = s_awvalid && s_awready;
            fw = s_wvalid && s_wready;
            @(posedge clk);
            @(negedge clk);
            cons_pop = 1'b0;
            if (fa) aw_done = 1;
            if (fw) w_done = 1;
            s_awvalid = 1'b0;
            s_wvalid  = 1'b0;
            if (!(aw_done && w_done)) begin
                chk(!s_bvalid, "R2 response before both channels", 64'(s_bvalid), 64'd0);
                @(negedge clk);
            end
        end
        chk(s_bvalid && s_bresp == 2'b00, "R2 response after both channels",
            64'({s_bvalid, s_bresp}), 64'({1'b1, 2'b00}));
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(s_bvalid, "R2 bvalid held", 64'(s_bvalid), 64'd1);
        end
        s_bready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_bready = 1'b0;
        chk(!s_bvalid, "R2 bvalid drops after bready", 64'(s_bvalid), 64'd0);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d, input int mode,
                            input int stall, input bit pop_at_commit);
        bit full_b  = (model_q.size() == DEPTH);
        bit empty_b = (model_q.size() == 0);
        axi_write(a, d, mode, stall, pop_at_commit);
        if (pop_at_commit && mode == 0 && !empty_b) void'(model_q.pop_front());
        case (a)
            4'h0: hi_m = d[7:0];
            4'h4: if (!full_b) model_q.push_back({hi_m, d}); else ovf_m = 1'b1;
            4'h8: begin
                run_m = d[0];
                if (d[3]) ovf_m = 1'b0;
            end
            default: ;
        endcase
        check_state();
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req, input int stall);
        logic [31:0] first;
        s_araddr  = a;
        s_arvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        chk(s_rvalid && s_rresp == 2'b00, "R8 read response", 64'({s_rvalid, s_rresp}), 64'({1'b1, 2'b00}));
        first = s_rdata;
        chk(s_rdata == exp, req, 64'(s_rdata), 64'(exp));
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(s_rvalid && s_rdata == first, "R8 read held", 64'(s_rdata), 64'(first));
        end
        s_rready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_rready = 1'b0;
        chk(!s_rvalid, "R8 rvalid drops", 64'(s_rvalid), 64'd0);
    endtask

    task automatic pop_one();
        cons_pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cons_pop = 1'b0;
        if (model_q.size() != 0) void'(model_q.pop_front());
        check_state();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!s_bvalid && !s_rvalid, "R1 no responses", 64'({s_bvalid, s_rvalid}), 64'd0);
        chk(cons_empty && !cons_run, "R1 consumer idle", 64'({cons_empty, cons_run}), 64'b10);
        rd_check(4'h8, 32'h2, "R1 status after reset", 0);

        // R3 word assembly, all channel orders
        do_write(4'h0, 32'hFFFF_FFA5, 0, 0, 0);
        do_write(4'h4, 32'h1234_5678, 1, 1, 0);
        chk(cons_data == 40'hA5_1234_5678, "R3 assembled item", 64'(cons_data), 64'hA5_1234_5678);
        do_write(4'h4, 32'h0000_0009, 2, 2, 0);
        chk(model_q[1] == 40'hA5_0000_0009, "R3 upper byte kept", 64'(model_q[1]), 64'hA5_0000_0009);

        // R8 data addresses read zero, status format
        rd_check(4'h0, 32'h0, "R8 upper address reads zero", 1);
        rd_check(4'h4, 32'h0, "R8 lower address reads zero", 0);
        rd_check(4'h8, exp_status(), "R8 status", 2);

        // R4 drain in order, R5 pop on empty
        pop_one();
        chk(cons_data == 40'hA5_0000_0009, "R4 second item", 64'(cons_data), 64'hA5_0000_0009);
        pop_one();
        pop_one();
        chk(cons_empty, "R5 pop while empty ignored", 64'(cons_empty), 64'd1);
        do_write(4'h4, 32'hCAFE_0001, 0, 0, 0);
        chk(cons_data == 40'hA5_CAFE_0001, "R5 state intact after empty pop", 64'(cons_data), 64'hA5_CAFE_0001);
        pop_one();

        // R6 fill to 16 then overflow
        for (int i = 0; i < DEPTH; i++) begin
            do_write(4'h0, 32'(i), $urandom_range(0, 2), 0, 0);
            do_write(4'h4, 32'h1000 + 32'(i), $urandom_range(0, 2), 0, 0);
        end
        rd_check(4'h8, 32'h4, "R6 full flag", 0);
        do_write(4'h4, 32'hDEAD_BEEF, 1, 0, 0);
        rd_check(4'h8, 32'hC, "R6 overflow set, item dropped", 0);
        chk(cons_data == 40'h00_0000_1000, "R6 head unchanged by drop", 64'(cons_data), 64'h00_0000_1000);
        // push at the same edge as a pop on a full FIFO: push blocked
        do_write(4'h4, 32'h5555_5555, 0, 0, 1);
        rd_check(4'h8, exp_status(), "R6 push blocked while full even with pop", 0);
        pop_one();
        rd_check(4'h8, exp_status(), "R6 overflow sticky", 0);

        // R7 control
        do_write(4'h8, 32'h0000_0001, 0, 0, 0);
        rd_check(4'h8, exp_status(), "R7 run set, overflow kept", 0);
        do_write(4'h8, 32'h0000_0009, 2, 1, 0);
        rd_check(4'h8, exp_status(), "R7 overflow cleared", 0);

        // R10 simultaneous push and pop
        do_write(4'h4, 32'h7777_0000, 0, 0, 1);
        rd_check(4'h8, exp_status(), "R10 push and pop same edge", 0);

        // R9 unmapped write
        do_write(4'hC, 32'hFFFF_FFFF, 1, 0, 0);
        rd_check(4'h8, exp_status(), "R9 unmapped write ignored", 0);
        chk(cons_run == 1'b1, "R9 run unchanged", 64'(cons_run), 64'd1);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            logic [31:0] d = $urandom;
            int mode = $urandom_range(0, 2);
            int st = $urandom_range(0, 2);
            case (op)
                0, 1:    do_write(4'h0, d, mode, st, 0);
                2, 3:    do_write(4'h4, d, mode, st, $urandom_range(0, 1) == 1);
                4:       do_write(4'h8, d & 32'h0000_000F, mode, st, 0);
                5:       do_write(4'hC, d, mode, st, 0);
                6, 7:    pop_one();
                8:       rd_check(4'h8, exp_status(), "R8 random status", st);
                default: rd_check(4'($urandom_range(0, 1) * 4), 32'h0, "R8 random data read zero", st);
            endcase
        end
        finish_run();
    end
endmodule